// File: doc/BRIEF.md
# Power-of-Two Card Clock Divider

This block derives the clock for a memory card from the base clock of its host controller. The division ratio comes from an 8-bit code in which a single set bit selects a power of two. Code zero passes the base rate through. The block holds the clock-control word itself. Software writes that word through a plain write strobe and reads it back on a parallel bus. The word carries an internal clock enable, a card clock enable, the divisor code and a self-clearing full reset command. A read-only stable flag in the word tells software when the internal clock may be used.

Two outputs drive the card side. `card_clk_o` is a registered-state square wave in the base domain, with half the period high and half low. `card_ce_o` is a one-cycle strobe at the start of each output period. Logic that runs on the base clock uses the strobe. For the undivided setting the strobe stays high and the square wave stays low, so the consumer runs directly on the base clock. A new divisor is applied only once the current output period has run out, so no shortened pulse reaches the card. Software is expected to pick the smallest divisor that keeps the card clock at or below its target.

Top module: `sdclk_gen`

## Requirements
- R1: For a code whose highest set bit is bit k (k = 0..7), the output period is N = 2^(k+1) base cycles. The period starts with one cycle of `card_ce_o` high. `card_clk_o` is high for the first N/2 cycles of the period and low for the last N/2.
- R2: With code 0x00 and the clock running, `card_ce_o` is high in every cycle and `card_clk_o` stays low.
- R3: A code with more than one bit set divides as if only its highest set bit were set (0x05 divides by 8).
- R4: The stable flag (read-back bit 1) rises exactly 8 base cycles after the internal enable (bit 0) is written high, provided the enable stays high.
- R5: The stable flag drops in the same cycle in which the internal enable reads back low.
- R6: `card_clk_o` and `card_ce_o` are both low whenever the internal enable, the stable flag or the card clock enable (bit 2) is low.
- R7: A divisor written while the clock runs takes effect only after the period in progress has completed. The old period finishes with its normal high and low phases.
- R8: A write with bit 24 set clears both enables and returns the divisor code to 0x00, whatever the other bits hold. The word then reads back as zero and both card outputs go low.
- R9: The read-back word holds the internal enable at bit 0, the stable flag at bit 1, the card enable at bit 2 and the divisor code at bits 15:8. All other bits read zero. Writing bit 1 has no effect.
- R10: After reset the read-back word is zero and both card outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Base clock |
| rst_ni | input | 1 | Synchronous reset, active low |
| ctl_we_i | input | 1 | Write strobe for the control word |
| ctl_wdata_i | input | 32 | Control word to write |
| ctl_rdata_o | output | 32 | Control word read-back, including the stable flag |
| card_clk_o | output | 1 | Divided card clock level |
| card_ce_o | output | 1 | One-cycle strobe at the start of each card clock period |

## Verification
A divisor write can land in the same cycle in which the period counter is mid-way through a period. That collision decides whether the old or the new ratio is in force. The bench provokes it by aligning on the period strobe and writing a new code one cycle later. Its scoreboard expects the old period to be completed cycle for cycle before the new rhythm begins. A full reset command is also written together with set enable and divisor bits, and the bench judges that the reset wins in the read-back and at both card outputs.

// File: rtl/sdclk_pkg.sv
package sdclk_pkg;
  localparam int WORD_W      = 32;
  localparam int POS_INT_EN  = 0;
  localparam int POS_STABLE  = 1;
  localparam int POS_CARD_EN = 2;
  localparam int POS_DIV_LSB = 8;
  localparam int POS_FULLRST = 24;
endpackage

// File: rtl/sdclk_ctl.sv
module sdclk_ctl
  import sdclk_pkg::*;
#(
  parameter int CODE_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [WORD_W-1:0] wdata_i,
  output logic              int_en_o,
  output logic              card_en_o,
  output logic [CODE_W-1:0] code_o
);
  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      int_en_o  <= 1'b0;
      card_en_o <= 1'b0;
      code_o    <= '0;
    end else if (we_i) begin
      if (wdata_i[POS_FULLRST]) begin
        int_en_o  <= 1'b0;
        card_en_o <= 1'b0;
        code_o    <= '0;
      end else begin
        int_en_o  <= wdata_i[POS_INT_EN];
        card_en_o <= wdata_i[POS_CARD_EN];
        code_o    <= wdata_i[POS_DIV_LSB +: CODE_W];
      end
    end
  end
endmodule

// File: rtl/sdclk_stab.sv
module sdclk_stab #(
  parameter int STABLE_CYCLES = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic int_en_i,
  output logic stable_o
);
  localparam int CW = $clog2(STABLE_CYCLES + 1);
  localparam logic [CW-1:0] LIMIT = CW'(STABLE_CYCLES);

  logic [CW-1:0] wait_q;

  always_ff @(posedge clk_i) begin
    if (!rst_ni || !int_en_i) begin
      wait_q <= '0;
    end else if (wait_q != LIMIT) begin
      wait_q <= wait_q + 1'b1;
    end
  end

  // Drops in the same cycle as the enable, rises once the count is full.
  assign stable_o = int_en_i && (wait_q == LIMIT);
endmodule

// File: rtl/sdclk_div.sv
module sdclk_div #(
  parameter int CODE_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              run_i,
  input  logic [CODE_W-1:0] code_i,
  output logic              clk_o,
  output logic              ce_o
);
  localparam int SH_W = $clog2(CODE_W + 1);

  logic [SH_W-1:0]   want_sh;
  logic [SH_W-1:0]   act_sh;
  logic [CODE_W-1:0] phase_q;
  logic [CODE_W:0]   period;
  logic [CODE_W:0]   period_m1;
  logic [CODE_W-1:0] last_ph;
  logic [CODE_W-1:0] half_ph;

  // Highest set bit wins: later iterations override earlier ones.
  always_comb begin
    want_sh = '0;
    for (int i = 0; i < CODE_W; i++) begin
      if (code_i[i]) want_sh = SH_W'(i + 1);
    end
  end

  assign period    = {{CODE_W{1'b0}}, 1'b1} << act_sh;
  assign period_m1 = period - 1'b1;
  assign last_ph   = period_m1[CODE_W-1:0];
  assign half_ph   = period[CODE_W:1];

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      phase_q <= '0;
      act_sh  <= '0;
    end else if (!run_i || phase_q == last_ph) begin
      phase_q <= '0;
      act_sh  <= want_sh;
    end else begin
      phase_q <= phase_q + 1'b1;
    end
  end

  assign ce_o  = run_i && (phase_q == '0);
  assign clk_o = run_i && (phase_q < half_ph);
endmodule

// File: rtl/sdclk_gen.sv
module sdclk_gen
  import sdclk_pkg::*;
#(
  parameter int CODE_W        = 8,
  parameter int STABLE_CYCLES = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ctl_we_i,
  input  logic [WORD_W-1:0] ctl_wdata_i,
  output logic [WORD_W-1:0] ctl_rdata_o,
  output logic              card_clk_o,
  output logic              card_ce_o
);
  logic              int_en;
  logic              card_en;
  logic              stable;
  logic              run;
  logic [CODE_W-1:0] code;

  sdclk_ctl #(.CODE_W(CODE_W)) u_ctl (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .we_i     (ctl_we_i),
    .wdata_i  (ctl_wdata_i),
    .int_en_o (int_en),
    .card_en_o(card_en),
    .code_o   (code)
  );

  sdclk_stab #(.STABLE_CYCLES(STABLE_CYCLES)) u_stab (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .int_en_i(int_en),
    .stable_o(stable)
  );

  assign run = int_en && stable && card_en;

  sdclk_div #(.CODE_W(CODE_W)) u_div (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .run_i (run),
    .code_i(code),
    .clk_o (card_clk_o),
    .ce_o  (card_ce_o)
  );

  always_comb begin
    ctl_rdata_o = '0;
    ctl_rdata_o[POS_INT_EN]               = int_en;
    ctl_rdata_o[POS_STABLE]               = stable;
    ctl_rdata_o[POS_CARD_EN]              = card_en;
    ctl_rdata_o[POS_DIV_LSB +: CODE_W]    = code;
  end
endmodule

// File: rtl/sdclk_gen_chk.sv
module sdclk_gen_chk
  import sdclk_pkg::*;
#(
  parameter int CODE_W        = 8,
  parameter int STABLE_CYCLES = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              ctl_we_i,
  input logic [WORD_W-1:0] ctl_wdata_i,
  input logic [WORD_W-1:0] ctl_rdata_o,
  input logic              card_clk_o,
  input logic              card_ce_o
);
  int en_run;

  always_ff @(posedge clk_i) begin
    if (!rst_ni || !ctl_rdata_o[POS_INT_EN]) en_run <= 0;
    else if (en_run < STABLE_CYCLES + 2) en_run <= en_run + 1;
  end

  a_r1_rise_on_strobe: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(card_clk_o) |-> card_ce_o);

  a_r4_stable_delay: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ctl_rdata_o[POS_STABLE]) |-> en_run == STABLE_CYCLES);

  a_r5_stable_needs_en: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctl_rdata_o[POS_STABLE] |-> ctl_rdata_o[POS_INT_EN]);

  a_r6_gated_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(ctl_rdata_o[POS_INT_EN] && ctl_rdata_o[POS_STABLE] && ctl_rdata_o[POS_CARD_EN])
      |-> (!card_clk_o && !card_ce_o));

  a_r8_full_reset: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctl_we_i && ctl_wdata_i[POS_FULLRST]) |=> (ctl_rdata_o == '0));

  a_r9_code_readback: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctl_we_i && !ctl_wdata_i[POS_FULLRST])
      |=> (ctl_rdata_o[POS_DIV_LSB +: CODE_W] == $past(ctl_wdata_i[POS_DIV_LSB +: CODE_W])));
endmodule

bind sdclk_gen sdclk_gen_chk #(.CODE_W(CODE_W), .STABLE_CYCLES(STABLE_CYCLES)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .ctl_we_i   (ctl_we_i),
  .ctl_wdata_i(ctl_wdata_i),
  .ctl_rdata_o(ctl_rdata_o),
  .card_clk_o (card_clk_o),
  .card_ce_o  (card_ce_o)
);

// File: tb/test_sdclk_gen.sv
`timescale 1ns/1ps
module test_sdclk_gen;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        we = 1'b0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        cclk;
  logic        cce;

  int    n_checks = 0;
  int    n_errors = 0;
  bit    done = 1'b0;
  bit    exp_q[$];
  string cur_tag = "R1";

  always #5 clk = ~clk;

  sdclk_gen i_sdclk_gen (
    .clk_i      (clk),
    .rst_ni     (rst_n),
    .ctl_we_i   (we),
    .ctl_wdata_i(wdata),
    .ctl_rdata_o(rdata),
    .card_clk_o (cclk),
    .card_ce_o  (cce)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", n_checks, n_errors);
      $finish;
    end
  endtask

  // Monitor: pops one expected card clock level per cycle.
  always @(negedge clk) begin
    if (exp_q.size() > 0) begin
      bit e;
      e = exp_q.pop_front();
      check(cclk == e, cur_tag, {31'b0, cclk}, {31'b0, e});
    end
  end

  task automatic write_word(input logic [31:0] w);
    @(negedge clk); #1;
    we = 1'b1; wdata = w;
    @(posedge clk); #1;
    we = 1'b0; wdata = '0;
  endtask

  // Returns just after a sampling point where the period strobe was seen.
  task automatic align_ce();
    do @(negedge clk); while (!cce);
    #1;
  endtask

  task automatic push_level(input bit v, input int n);
    for (int i = 0; i < n; i++) exp_q.push_back(v);
  endtask

  task automatic drain();
    wait (exp_q.size() == 0);
  endtask

  initial begin
    #1_000_000;
    n_errors++;
    $display("FAIL watchdog actual=hung expected=done");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    // R10 reset state
    check(rdata == 32'h0, "R10", rdata, 32'h0);
    check(!cclk && !cce, "R10", {30'b0, cclk, cce}, 32'h0);

    // R9: writing only the stable bit has no effect
    write_word(32'h0000_0002);
    @(negedge clk);
    check(rdata == 32'h0, "R9", rdata, 32'h0);

    // R4, R6: enable everything, divide by 4
    write_word(32'h0000_0205);
    for (int i = 0; i <= 8; i++) begin
      @(negedge clk);
      check(rdata[1] == (i == 8), "R4", {31'b0, rdata[1]}, {31'b0, i == 8});
      check(cclk == (i == 8), "R6", {31'b0, cclk}, {31'b0, i == 8});
    end
    check(rdata == 32'h0000_0207, "R9", rdata, 32'h0000_0207);

    // R1: divide by 4, periods 1100
    cur_tag = "R1";
    align_ce();
    push_level(1, 1); push_level(0, 2);
    push_level(1, 2); push_level(0, 2);
    push_level(1, 2); push_level(0, 2);
    drain();

    // R7: change to divide by 16 just after a period start
    cur_tag = "R7";
    align_ce();
    push_level(1, 1); push_level(0, 2);
    push_level(1, 8); push_level(0, 8);
    we = 1'b1; wdata = 32'h0000_0805;
    @(posedge clk); #1;
    we = 1'b0; wdata = '0;
    drain();

    // R3: 0x05 acts as 0x04, divide by 8
    cur_tag = "R3";
    write_word(32'h0000_0505);
    align_ce(); align_ce();
    push_level(1, 3); push_level(0, 4);
    push_level(1, 4); push_level(0, 4);
    drain();

    // R1: top code, divide by 256
    cur_tag = "R1";
    write_word(32'h0000_8005);
    align_ce(); align_ce();
    push_level(1, 127); push_level(0, 128);
    push_level(1, 1);
    drain();

    // R2: code zero, strobe every cycle, level low
    write_word(32'h0000_0005);
    align_ce(); align_ce();
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      check(cce && !cclk, "R2", {30'b0, cclk, cce}, 32'h1);
    end

    // R6: card enable low while stable
    write_word(32'h0000_0201);
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      check(!cclk && !cce && rdata[1], "R6", {29'b0, rdata[1], cclk, cce}, 32'h4);
    end

    // R5: internal enable dropped, stable clears at once
    write_word(32'h0000_0204);
    @(negedge clk);
    check(rdata == 32'h0000_0204, "R5", rdata, 32'h0000_0204);
    check(!cclk && !cce, "R6", {30'b0, cclk, cce}, 32'h0);

    // R8: full reset wins over enable and divisor bits
    write_word(32'h0000_0205);
    repeat (12) @(negedge clk);
    check(rdata == 32'h0000_0207, "R4", rdata, 32'h0000_0207);
    write_word(32'h0100_0205);
    @(negedge clk);
    check(rdata == 32'h0, "R8", rdata, 32'h0);
    check(!cclk && !cce, "R8", {30'b0, cclk, cce}, 32'h0);

    repeat (3) @(negedge clk);
    finish_run();
  end
endmodule